// File: doc/BRIEF.md
# Two-Level Non-Inclusive Cache Tag Controller

This block models the tag side of a two-level cache hierarchy. A core presents read requests with a 32-bit byte address. The controller looks the line up in a small first-level tag store and in a larger second-level tag store, and reports whether the line came from the first level, the second level or main memory. On a miss in both levels it asks a simple memory port for the line. When the fill acknowledgement comes back, it installs the line in both levels.

The hierarchy is neither inclusive nor exclusive. A second-level hit copies the line into the first level and leaves the second-level contents alone. A second-level eviction never removes the same line from the first level. Only tags, valid bits and least-recently-used order are kept, with no data arrays. Each level reports a victim line on a one-cycle strobe whenever an install pushes out a valid line.

Top module: `nic_cache_top`

## Requirements
- R1: After reset both tag stores hold no valid line. `req_ready` is 1 and `resp_valid` is 0, and the first access to any line is answered with source code 2'b10 (memory).
- R2: The lookup ignores address bits [5:0], so two addresses that differ only in those bits name the same 64-byte line. `resp_addr` is the line base, with bits [5:0] at zero.
- R3: A first-level hit answers with source 2'b00. It issues no memory request, raises no eviction strobe and changes only first-level replacement order.
- R4: A request that misses the first level and hits the second answers with source 2'b01 and issues no memory request. It installs the line in the first level, so the next access to that line answers 2'b00. It raises no second-level eviction strobe.
- R5: A request that misses both levels raises `mem_req_valid` for exactly one cycle, with the line base on `mem_req_addr`. The answer comes with source 2'b10 one cycle after `mem_fill_ack`, and the line is then installed in both levels.
- R6: The first-level set is address bits [8:6] (8 sets, 2 ways) and the second-level set is bits [10:6] (32 sets, 4 ways). The remaining upper bits form the tag, and a line may sit in any way of its set.
- R7: An install into a full set replaces the least recently used way of that set. The order is updated on every hit and every install in that level. The matching eviction strobe carries the line base of the victim for one cycle, in the same cycle as `resp_valid`.
- R8: A second-level eviction sends no invalidation to the first level. A line evicted from the second level but still held in the first level is still answered with source 2'b00.
- R9: Only one request is in flight. `req_ready` is 0 from the cycle after a request is accepted until the cycle in which its answer is given.

Source code values on `resp_src` are 2'b00 for the first level, 2'b01 for the second level and 2'b10 for memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 32 | Byte address of the request |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_src | output | 2 | Where the line was found: 00 first level, 01 second level, 10 memory |
| resp_addr | output | 32 | Line base of the answered request |
| mem_req_valid | output | 1 | One-cycle line-fill request to memory |
| mem_req_addr | output | 32 | Line base to fetch |
| mem_fill_ack | input | 1 | Memory has returned the requested line |
| l1_evict_valid | output | 1 | A valid first-level line was replaced |
| l1_evict_addr | output | 32 | Line base of the first-level victim |
| l2_evict_valid | output | 1 | A valid second-level line was replaced |
| l2_evict_addr | output | 32 | Line base of the second-level victim |

## Verification
On a full miss into sets that are full in both levels, the two eviction strobes fire in the same cycle as the memory answer. Each carries a different victim chosen by that level's own replacement order. The bench provokes this with directed runs of five lines sharing one second-level set, and with random addresses over 256 lines. A bench model of both levels predicts both victims and checks them in that one cycle. A directed sequence then checks that the first-level copy of the second-level victim still hits.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFFSET_W = 6;
    localparam int LINE_W   = ADDR_W - OFFSET_W;

    typedef enum logic [1:0] {
        SRC_L1  = 2'b00,
        SRC_L2  = 2'b01,
        SRC_MEM = 2'b10
    } src_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } evict_t;

    function automatic logic [ADDR_W-1:0] line_to_addr(input logic [LINE_W-1:0] ln);
        return {ln, {OFFSET_W{1'b0}}};
    endfunction
endpackage

// File: rtl/nic_tag_level.sv
module nic_tag_level
    import nic_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = LINE_W - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] lk_line,
    output logic              hit,
    output evict_t            victim,
    input  logic              upd_en,
    input  logic              upd_install
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0] age_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [WAY_W-1:0] hit_way, vic_way, tgt_way;
    logic             vic_found;

    assign set_idx = lk_line[SET_W-1:0];
    assign tag_in  = lk_line[LINE_W-1 -: TAG_W];
    assign tgt_way = upd_install ? vic_way : hit_way;

    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        vic_way   = '0;
        vic_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && valid_q[set_idx][w] && tag_q[set_idx][w] == tag_in) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_found && !valid_q[set_idx][w]) begin
                vic_found = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        if (!vic_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_idx][w] == WAY_W'(WAYS - 1))
                    vic_way = WAY_W'(w);
            end
        end
        victim.valid = valid_q[set_idx][vic_way];
        victim.addr  = line_to_addr({tag_q[set_idx][vic_way], set_idx});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tgt_way)
                    age_q[set_idx][w] <= '0;
                else if (age_q[set_idx][w] < age_q[set_idx][tgt_way])
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
            if (upd_install) begin
                valid_q[set_idx][tgt_way] <= 1'b1;
                tag_q[set_idx][tgt_way]   <= tag_in;
            end
        end
    end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
    import nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    output logic              req_ready,
    output logic [LINE_W-1:0] cur_line,
    input  logic              l1_hit,
    input  logic              l2_hit,
    input  evict_t            l1_victim,
    input  evict_t            l2_victim,
    input  logic              mem_fill_ack,
    output logic              l1_upd_en,
    output logic              l1_install,
    output logic              l2_upd_en,
    output logic              l2_install,
    output logic              resp_valid,
    output src_e              resp_src,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output evict_t            l1_ev,
    output evict_t            l2_ev
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL} state_e;
    state_e state_q;

    logic look_l1, look_l2, look_miss, fill_done;

    assign req_ready = (state_q == ST_IDLE);
    assign look_l1   = (state_q == ST_LOOK) && l1_hit;
    assign look_l2   = (state_q == ST_LOOK) && !l1_hit && l2_hit;
    assign look_miss = (state_q == ST_LOOK) && !l1_hit && !l2_hit;
    assign fill_done = (state_q == ST_FILL) && mem_fill_ack;

    assign l1_upd_en  = look_l1 || look_l2 || fill_done;
    assign l1_install = look_l2 || fill_done;
    assign l2_upd_en  = look_l2 || fill_done;
    assign l2_install = fill_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            cur_line      <= '0;
            resp_valid    <= 1'b0;
            resp_src      <= SRC_L1;
            resp_addr     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            l1_ev         <= '0;
            l2_ev         <= '0;
        end else begin
            resp_valid    <= 1'b0;
            mem_req_valid <= 1'b0;
            l1_ev.valid   <= 1'b0;
            l2_ev.valid   <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cur_line <= req_line;
                    state_q  <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (look_miss) begin
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= line_to_addr(cur_line);
                        state_q       <= ST_FILL;
                    end else begin
                        resp_valid <= 1'b1;
                        resp_src   <= look_l1 ? SRC_L1 : SRC_L2;
                        resp_addr  <= line_to_addr(cur_line);
                        if (look_l2) l1_ev <= l1_victim;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_FILL: if (fill_done) begin
                    resp_valid <= 1'b1;
                    resp_src   <= SRC_MEM;
                    resp_addr  <= line_to_addr(cur_line);
                    l1_ev      <= l1_victim;
                    l2_ev      <= l2_victim;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nic_cache_top.sv
module nic_cache_top
    import nic_pkg::*;
#(
    parameter int L1_WAYS = 2,
    parameter int L1_SETS = 8,
    parameter int L2_WAYS = 4,
    parameter int L2_SETS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_src,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_fill_ack,
    output logic              l1_evict_valid,
    output logic [ADDR_W-1:0] l1_evict_addr,
    output logic              l2_evict_valid,
    output logic [ADDR_W-1:0] l2_evict_addr
);
    logic              unused_offset;
    logic [LINE_W-1:0] cur_line;
    logic              l1_hit, l2_hit;
    evict_t            l1_victim, l2_victim, l1_ev, l2_ev;
    logic              l1_upd_en, l1_install, l2_upd_en, l2_install;
    src_e              src;

    assign unused_offset = ^req_addr[OFFSET_W-1:0];

    nic_tag_level #(.WAYS(L1_WAYS), .SETS(L1_SETS)) u_l1 (
        .clk(clk), .rst(rst), .lk_line(cur_line), .hit(l1_hit),
        .victim(l1_victim), .upd_en(l1_upd_en), .upd_install(l1_install)
    );

    nic_tag_level #(.WAYS(L2_WAYS), .SETS(L2_SETS)) u_l2 (
        .clk(clk), .rst(rst), .lk_line(cur_line), .hit(l2_hit),
        .victim(l2_victim), .upd_en(l2_upd_en), .upd_install(l2_install)
    );

    nic_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_line(req_addr[ADDR_W-1:OFFSET_W]),
        .req_ready(req_ready), .cur_line(cur_line),
        .l1_hit(l1_hit), .l2_hit(l2_hit),
        .l1_victim(l1_victim), .l2_victim(l2_victim),
        .mem_fill_ack(mem_fill_ack),
        .l1_upd_en(l1_upd_en), .l1_install(l1_install),
        .l2_upd_en(l2_upd_en), .l2_install(l2_install),
        .resp_valid(resp_valid), .resp_src(src), .resp_addr(resp_addr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .l1_ev(l1_ev), .l2_ev(l2_ev)
    );

    assign resp_src       = src;
    assign l1_evict_valid = l1_ev.valid;
    assign l1_evict_addr  = l1_ev.addr;
    assign l2_evict_valid = l2_ev.valid;
    assign l2_evict_addr  = l2_ev.addr;
endmodule

// File: rtl/nic_cache_chk.sv
module nic_cache_chk
    import nic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_src,
    input logic [ADDR_W-1:0] resp_addr,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              l1_evict_valid,
    input logic [ADDR_W-1:0] l1_evict_addr,
    input logic              l2_evict_valid,
    input logic [ADDR_W-1:0] l2_evict_addr
);
    p_src_legal_r5: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_src != 2'b11);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_with_resp_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);

    p_mem_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_mem_line_base_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[OFFSET_W-1:0] == '0);

    p_resp_line_base_r2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_addr[OFFSET_W-1:0] == '0);

    p_l1_evict_not_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
        l1_evict_valid |-> (resp_valid && resp_src != 2'b00));

    p_l2_untouched_on_l2hit_r4: assert property (@(posedge clk) disable iff (rst)
        l2_evict_valid |-> (resp_valid && resp_src == 2'b10));

    p_evict_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        l1_evict_valid |=> !l1_evict_valid);

    p_evict_base_r7: assert property (@(posedge clk) disable iff (rst)
        (l1_evict_valid || l2_evict_valid) |->
        (l1_evict_addr[OFFSET_W-1:0] == '0 && l2_evict_addr[OFFSET_W-1:0] == '0));
endmodule

bind nic_cache_top nic_cache_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_src(resp_src), .resp_addr(resp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .l1_evict_valid(l1_evict_valid), .l1_evict_addr(l1_evict_addr),
    .l2_evict_valid(l2_evict_valid), .l2_evict_addr(l2_evict_addr)
);

// File: tb/nic_cache_top_test.sv
`timescale 1ns/1ps
module nic_cache_top_test;
    localparam int MEM_LAT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic [1:0]  resp_src;
    logic [31:0] resp_addr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_fill_ack = 1'b0;
    logic        l1_evict_valid, l2_evict_valid;
    logic [31:0] l1_evict_addr, l2_evict_addr;

    always #10 clk = ~clk;

    nic_cache_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_src(resp_src),
        .resp_addr(resp_addr), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_fill_ack(mem_fill_ack),
        .l1_evict_valid(l1_evict_valid), .l1_evict_addr(l1_evict_addr),
        .l2_evict_valid(l2_evict_valid), .l2_evict_addr(l2_evict_addr)
    );

    int n_total = 0;
    int n_fail  = 0;

    // Bench model of both levels: index 0 first level, 1 second level.
    int          nways [2] = '{2, 4};
    int          nsets [2] = '{8, 32};
    bit          mv    [2][32][4];
    int unsigned mline [2][32][4];
    int          mage  [2][32][4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    task automatic model_clear();
        for (int l = 0; l < 2; l++)
            for (int s = 0; s < 32; s++)
                for (int w = 0; w < 4; w++) begin
                    mv[l][s][w] = 1'b0; mline[l][s][w] = 0; mage[l][s][w] = w;
                end
    endtask

    function automatic int model_find(input int l, input int unsigned ln);
        int s = int'(ln % nsets[l]);
        for (int w = 0; w < nways[l]; w++)
            if (mv[l][s][w] && mline[l][s][w] == ln) return w;
        return -1;
    endfunction

    task automatic model_touch(input int l, input int s, input int tw);
        int ref_age = mage[l][s][tw];
        for (int w = 0; w < nways[l]; w++)
            if (w == tw) mage[l][s][w] = 0;
            else if (mage[l][s][w] < ref_age) mage[l][s][w]++;
    endtask

    task automatic model_install(input int l, input int unsigned ln,
                                 output bit ev, output logic [31:0] ea);
        int s = int'(ln % nsets[l]);
        int vw = -1;
        for (int w = 0; w < nways[l]; w++)
            if (vw < 0 && !mv[l][s][w]) vw = w;
        if (vw < 0)
            for (int w = 0; w < nways[l]; w++)
                if (mage[l][s][w] == nways[l] - 1) vw = w;
        ev = mv[l][s][vw];
        ea = mline[l][s][vw] << 6;
        mv[l][s][vw] = 1'b1;
        mline[l][s][vw] = ln;
        model_touch(l, s, vw);
    endtask

    task automatic model_access(input logic [31:0] a, output logic [1:0] src,
                                output bit e1v, output logic [31:0] e1a,
                                output bit e2v, output logic [31:0] e2a);
        int unsigned ln = a >> 6;
        int w1 = model_find(0, ln);
        int w2 = model_find(1, ln);
        e1v = 1'b0; e1a = '0; e2v = 1'b0; e2a = '0;
        if (w1 >= 0) begin
            src = 2'b00;
            model_touch(0, int'(ln % 8), w1);
        end else if (w2 >= 0) begin
            src = 2'b01;
            model_touch(1, int'(ln % 32), w2);
            model_install(0, ln, e1v, e1a);
        end else begin
            src = 2'b10;
            model_install(0, ln, e1v, e1a);
            model_install(1, ln, e2v, e2a);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        check("R1 no response after reset", {31'b0, resp_valid}, 32'd0);
    endtask

    // Issues one request, plays the memory, and checks the answer.
    task automatic do_req(input logic [31:0] a, output logic [1:0] got_src);
        logic [1:0]  esrc;
        bit          e1v, e2v;
        logic [31:0] e1a, e2a;
        int          cd = 0, nmem = 0, guard = 0, busy_bad = 0;
        logic [31:0] maddr = '0;
        model_access(a, esrc, e1v, e1a, e2v, e2a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_fill_ack) mem_fill_ack = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) mem_fill_ack = 1'b1;
            end
            if (mem_req_valid) begin
                nmem++;
                maddr = mem_req_addr;
                cd = MEM_LAT;
            end
            if (resp_valid) break;
            if (req_ready) busy_bad++;
            guard++;
            if (guard > 200) begin
                check("R9 answer arrives", 32'd0, 32'd1);
                finish_run();
            end
        end
        got_src = resp_src;
        mem_fill_ack = 1'b0;
        check("R3/R4/R5 source code", {30'b0, resp_src}, {30'b0, esrc});
        check("R2 answer line base", resp_addr, {a[31:6], 6'b0});
        check("R9 ready low while busy", busy_bad, 0);
        check("R5 memory request count", nmem, (esrc == 2'b10) ? 1 : 0);
        if (esrc == 2'b10) check("R5 memory line address", maddr, {a[31:6], 6'b0});
        check("R7 first-level evict strobe", {31'b0, l1_evict_valid}, {31'b0, e1v});
        if (e1v) check("R7 first-level victim", l1_evict_addr, e1a);
        check("R4 second-level evict strobe", {31'b0, l2_evict_valid}, {31'b0, e2v});
        if (e2v) check("R7 second-level victim", l2_evict_addr, e2a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] s;
        void'($urandom(32'd4242));
        do_reset();

        // R1, R2, R3: first touch from memory, offset ignored, then hit.
        do_req(32'h0000_0000, s); check("R1 first access from memory", {30'b0, s}, 32'd2);
        do_req(32'h0000_002B, s); check("R2 offset ignored", {30'b0, s}, 32'd0);
        do_req(32'h0000_003F, s); check("R3 first-level hit", {30'b0, s}, 32'd0);

        // R4, R6: three lines in first-level set 0 but separate second-level sets.
        do_req(32'h0000_0200, s);
        do_req(32'h0000_0400, s); check("R7 LRU miss fills", {30'b0, s}, 32'd2);
        do_req(32'h0000_0000, s); check("R4 second-level hit", {30'b0, s}, 32'd1);
        do_req(32'h0000_0010, s); check("R4 line copied to first level", {30'b0, s}, 32'd0);
        do_req(32'h0000_0040, s); check("R6 other set misses", {30'b0, s}, 32'd2);

        // R8: second-level eviction keeps the first-level copy.
        do_reset();
        do_req(32'h0001_0000, s);
        do_req(32'h0001_0800, s);
        do_req(32'h0001_0000, s);
        do_req(32'h0001_1000, s);
        do_req(32'h0001_0000, s);
        do_req(32'h0001_1800, s);
        do_req(32'h0001_0000, s); check("R8 line kept hot in first level", {30'b0, s}, 32'd0);
        do_req(32'h0001_2000, s); check("R7 full miss both levels", {30'b0, s}, 32'd2);
        check("R8 second level evicted hot line", l2_evict_addr, 32'h0001_0000);
        do_req(32'h0001_0000, s); check("R8 no back-invalidation", {30'b0, s}, 32'd0);

        // Random traffic over 256 lines.
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom & 32'h0000_3FFF;
            if (i % 4 == 0) a = $urandom & 32'h0000_03FF;
            do_req(a, s);
        end
        finish_run();
    end
endmodule